// File: doc/BRIEF.md
# Slave Boot Load Sequencer

This block sits on the host side of a target processor's slave memory port and boots that target from a boot image. The image reaches it as a stream of items. A header item opens a record and names a memory type and a start address. Word items then carry the record's words. An end item closes the image. The sequencer turns these items into single I/O write accesses on a 16-bit bus. Accesses with address bit 0 set latch an address into the target. Accesses with bit 0 clear write a data word, and the target increments its address after each one.

The sequencer first puts the target into port-boot mode. It holds the memory-map strap low and the boot-mode strap high, keeps the target in reset for a fixed number of cycles and then releases it. After that it streams program records and then data records. A 24-bit program word goes out as two bus writes. The word for program address 0 is the restart vector, and writing it starts the target. The sequencer therefore keeps that word in a register and writes it only after the whole image has been sent.

The image stream is valid/ready. An item is taken on a clock edge where `in_valid` and `in_ready` are both high. The source must hold `in_kind` and `in_data` steady while `in_valid` is high and `in_ready` is low. `in_ready` is high only while the sequencer is idle with no bus access in flight. Every item therefore waits until the previous word's writes have been acknowledged.

Top module: `slave_boot_loader`

## Requirements
- R1: After reset, `tgt_map_sel` is 0 and `tgt_boot_sel` is 1 at all times. `tgt_rst_n` stays low for RST_CYCLES clock edges after `rst_n` is released and then stays high. No item is accepted before that.
- R2: An item is taken when `in_valid` and `in_ready` are both high, and `in_ready` is never high while a bus access is active. Item kind codes on `in_kind`: 2'b01 header, 2'b10 word, 2'b11 end, 2'b00 invalid. In a header, `in_data[23:22]` is the type (2'b01 program, 2'b10 data) and `in_data[21:0]` is the start address.
- R3: Each record's first transferred word is preceded by one latch access with `io_a0`=1 and `io_data` = {1'b0, type bit, 14-bit address}, where bit 14 is 1 for program and 0 for data. A header followed by no words produces no access.
- R4: A program word goes out as two accesses with `io_a0`=0: first `in_data[23:8]`, then {8'h00, `in_data[7:0]`}. A data word goes out as one access carrying `in_data[15:0]`. Later words of a record get no further latch.
- R5: The first word of a program record that starts at address 0 is held as the restart vector and not written. The record's remaining words are latched to program address 1.
- R6: On the end item the sequencer latches 16'h4000 and writes the two halves of the vector. It then raises `done`, which stays high, at the edge that samples the last acknowledge. `done` is never high while expected writes are still outstanding.
- R7: During an access, `io_sel_n` and `io_wr_n` are low together, and `io_a0` and `io_data` hold steady until `ack_n` is sampled low. Both strobes then go high for at least one cycle before the next access.
- R8: `tgt_latch` equals `io_a0` and `tgt_wr_n` equals `io_a0 | io_wr_n`, so a latch and a data write are never active together.
- R9: The sequencer sets a sticky `err` on any of these: invalid kind, unknown header type, header address above 0x3FFF, a word past address 0x3FFF, a word before any header, a program header after a data header, or an end item with no vector. After that it makes no further access, keeps `in_ready` low and never raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Image item valid |
| in_ready | output | 1 | Sequencer can take an item |
| in_kind | input | 2 | Item kind code |
| in_data | input | 24 | Item payload |
| tgt_rst_n | output | 1 | Target reset, active low |
| tgt_map_sel | output | 1 | Memory-map strap to target |
| tgt_boot_sel | output | 1 | Boot-mode strap to target |
| io_sel_n | output | 1 | Host I/O space select, active low |
| io_wr_n | output | 1 | Host write strobe, active low |
| io_a0 | output | 1 | Host I/O address bit 0 |
| io_data | output | 16 | Host I/O data bus |
| tgt_latch | output | 1 | Target address-latch strobe |
| tgt_wr_n | output | 1 | Target data write strobe, active low |
| ack_n | input | 1 | Target acknowledge, active low |
| done | output | 1 | Restart vector written |
| err | output | 1 | Sticky image error |

## Verification
A wrong internal address counter or a missed latch request shows up on the first bus access of the next word. There the latched value or the payload differs from the bench's own transaction list. A restart vector captured at the wrong time appears either as an early access with the 16'h4000 latch pattern or as a program write that the list does not contain. An error flag that is not sticky, or a state that leaks past an error, is seen within a few cycles: `in_ready` rises again, or an access appears after the list has run dry. The bench compares strobes, straps and handshake rules on every clock and every access against that list.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
  localparam int OP_W  = 24;
  localparam int BUS_W = 16;

  typedef enum logic [1:0] {
    K_BAD  = 2'b00,
    K_HDR  = 2'b01,
    K_WORD = 2'b10,
    K_END  = 2'b11
  } item_kind_t;

  localparam logic [1:0] T_PROG = 2'b01;
  localparam logic [1:0] T_DATA = 2'b10;

  typedef enum logic [3:0] {
    ST_WAITRST, ST_IDLE, ST_LATCH, ST_HI, ST_LO, ST_DW,
    ST_VLATCH, ST_VHI, ST_VLO, ST_DONE, ST_ERR
  } seq_state_t;

  function automatic logic [BUS_W-1:0] op_upper(input logic [OP_W-1:0] w);
    return w[OP_W-1:OP_W-BUS_W];
  endfunction

  function automatic logic [BUS_W-1:0] op_lower(input logic [OP_W-1:0] w);
    return {{(2*BUS_W-OP_W){1'b0}}, w[OP_W-BUS_W-1:0]};
  endfunction
endpackage

// File: rtl/sbl_strap_ctrl.sv
module sbl_strap_ctrl #(
  parameter int HOLD = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tgt_rst_n,
  output logic map_sel,
  output logic boot_sel,
  output logic released
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign released  = (cnt == LIMIT);
  assign tgt_rst_n = released;
  assign map_sel   = 1'b0;
  assign boot_sel  = 1'b1;

  p_release_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    released |=> released);
endmodule

// File: rtl/sbl_bus_port.sv
module sbl_bus_port #(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             req_a0,
  input  logic [BUS_W-1:0] req_data,
  input  logic             ack_n,
  output logic             free,
  output logic             acc_done,
  output logic             io_sel_n,
  output logic             io_wr_n,
  output logic             io_a0,
  output logic [BUS_W-1:0] io_data
);
  logic             busy;
  logic             a0_q;
  logic [BUS_W-1:0] d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      a0_q <= 1'b0;
      d_q  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      a0_q <= req_a0;
      d_q  <= req_data;
    end else if (busy && !ack_n) begin
      busy <= 1'b0;
    end
  end

  assign free     = !busy;
  assign acc_done = busy && !ack_n;
  assign io_sel_n = !busy;
  assign io_wr_n  = !busy;
  assign io_a0    = busy && a0_q;
  assign io_data  = d_q;

  p_gap_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ack_n) |=> !busy);
  p_hold_until_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ack_n) |=> (busy && $stable(d_q) && $stable(a0_q)));
  p_start_when_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/slave_boot_loader.sv
module slave_boot_loader
  import sbl_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int RST_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_kind,
  input  logic [OP_W-1:0]  in_data,
  output logic             tgt_rst_n,
  output logic             tgt_map_sel,
  output logic             tgt_boot_sel,
  output logic             io_sel_n,
  output logic             io_wr_n,
  output logic             io_a0,
  output logic [BUS_W-1:0] io_data,
  output logic             tgt_latch,
  output logic             tgt_wr_n,
  input  logic             ack_n,
  output logic             done,
  output logic             err
);
  localparam int CNT_W = ADDR_W + 1;
  localparam int HA_W  = OP_W - 2;
  localparam logic [HA_W-1:0] ADDR_MAX = HA_W'((1 << ADDR_W) - 1);
  localparam logic [BUS_W-1:0] VEC_LATCH = BUS_W'({1'b1, {ADDR_W{1'b0}}});

  seq_state_t       st;
  logic             launched;
  logic [CNT_W-1:0] cur;
  logic             is_pm, pend, vec_next, vec_have, seen_dm, rec_open;
  logic [OP_W-1:0]  vec, wbuf;

  logic             released, free, acc_done, start, req_a0, issuing;
  logic [BUS_W-1:0] req_data, lat_word;
  logic [1:0]       hdr_type;
  logic [HA_W-1:0]  hdr_addr;
  logic             hdr_bad;

  sbl_strap_ctrl #(.HOLD(RST_CYCLES)) u_strap (
    .clk(clk), .rst_n(rst_n), .tgt_rst_n(tgt_rst_n),
    .map_sel(tgt_map_sel), .boot_sel(tgt_boot_sel), .released(released)
  );

  sbl_bus_port #(.BUS_W(BUS_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .start(start), .req_a0(req_a0),
    .req_data(req_data), .ack_n(ack_n), .free(free), .acc_done(acc_done),
    .io_sel_n(io_sel_n), .io_wr_n(io_wr_n), .io_a0(io_a0), .io_data(io_data)
  );

  assign tgt_latch = io_a0;
  assign tgt_wr_n  = io_a0 | io_wr_n;

  assign hdr_type = in_data[OP_W-1:OP_W-2];
  assign hdr_addr = in_data[HA_W-1:0];
  assign hdr_bad  = (hdr_type != T_PROG && hdr_type != T_DATA) ||
                    (hdr_addr > ADDR_MAX) ||
                    (hdr_type == T_PROG && seen_dm);
  assign lat_word = BUS_W'({is_pm, cur[ADDR_W-1:0]});

  always_comb begin
    req_a0   = 1'b0;
    req_data = '0;
    issuing  = 1'b1;
    case (st)
      ST_LATCH:  begin req_a0 = 1'b1; req_data = lat_word;  end
      ST_HI:     req_data = op_upper(wbuf);
      ST_LO:     req_data = op_lower(wbuf);
      ST_DW:     req_data = wbuf[BUS_W-1:0];
      ST_VLATCH: begin req_a0 = 1'b1; req_data = VEC_LATCH; end
      ST_VHI:    req_data = op_upper(vec);
      ST_VLO:    req_data = op_lower(vec);
      default:   issuing = 1'b0;
    endcase
  end

  assign start    = issuing && !launched && free;
  assign in_ready = (st == ST_IDLE);
  assign done     = (st == ST_DONE);
  assign err      = (st == ST_ERR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_WAITRST; launched <= 1'b0; cur <= '0;
      is_pm <= 1'b0; pend <= 1'b0; vec_next <= 1'b0; vec_have <= 1'b0;
      seen_dm <= 1'b0; rec_open <= 1'b0; vec <= '0; wbuf <= '0;
    end else begin
      if (start) launched <= 1'b1;
      if (acc_done) begin
        launched <= 1'b0;
        case (st)
          ST_LATCH:  st <= is_pm ? ST_HI : ST_DW;
          ST_HI:     st <= ST_LO;
          ST_LO,
          ST_DW:     begin st <= ST_IDLE; cur <= cur + 1'b1; end
          ST_VLATCH: st <= ST_VHI;
          ST_VHI:    st <= ST_VLO;
          ST_VLO:    st <= ST_DONE;
          default:   st <= st;
        endcase
      end
      case (st)
        ST_WAITRST: if (released) st <= ST_IDLE;
        ST_IDLE: if (in_valid) begin
          case (item_kind_t'(in_kind))
            K_HDR: begin
              if (hdr_bad) st <= ST_ERR;
              else begin
                is_pm    <= (hdr_type == T_PROG);
                cur      <= hdr_addr[CNT_W-1:0];
                pend     <= 1'b1;
                rec_open <= 1'b1;
                vec_next <= (hdr_type == T_PROG) && (hdr_addr == '0);
                if (hdr_type == T_DATA) seen_dm <= 1'b1;
              end
            end
            K_WORD: begin
              if (!rec_open) st <= ST_ERR;
              else if (vec_next) begin
                vec      <= in_data;
                vec_have <= 1'b1;
                vec_next <= 1'b0;
                cur      <= CNT_W'(1);
              end else if (cur[ADDR_W]) st <= ST_ERR;
              else begin
                wbuf <= in_data;
                pend <= 1'b0;
                st   <= pend ? ST_LATCH : (is_pm ? ST_HI : ST_DW);
              end
            end
            K_END:   st <= vec_have ? ST_VLATCH : ST_ERR;
            default: st <= ST_ERR;
          endcase
        end
        default: ;
      endcase
    end
  end

  p_ready_bus_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> io_wr_n);
  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (err && io_wr_n && !in_ready));
  p_done_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  p_no_item_in_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_rst_n |-> !in_ready);
endmodule

// File: tb/sim_slave_boot_loader.sv
module sim_slave_boot_loader;
  localparam int RST_CYC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] in_kind = 2'b00;
  logic [23:0] in_data = '0;
  logic ack_n = 1'b1;
  logic in_ready, tgt_rst_n, tgt_map_sel, tgt_boot_sel;
  logic io_sel_n, io_wr_n, io_a0, tgt_latch, tgt_wr_n, done, err;
  logic [15:0] io_data;

  always #10 clk = ~clk;

  slave_boot_loader #(.ADDR_W(14), .RST_CYCLES(RST_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_data(in_data), .tgt_rst_n(tgt_rst_n),
    .tgt_map_sel(tgt_map_sel), .tgt_boot_sel(tgt_boot_sel),
    .io_sel_n(io_sel_n), .io_wr_n(io_wr_n), .io_a0(io_a0), .io_data(io_data),
    .tgt_latch(tgt_latch), .tgt_wr_n(tgt_wr_n), .ack_n(ack_n),
    .done(done), .err(err)
  );

  int vectors = 0;
  int fails = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // expected access list: [18:17] tag (0=R3,1=R4,2=R5,3=R6), [16] a0, [15:0] data
  logic [18:0] exp_q[$];
  bit b_pm, b_pend, b_vecnext, b_vechave, b_seendm, b_open, b_shift, b_err;
  int b_cur;
  logic [23:0] b_vec;

  task automatic model_clear();
    exp_q.delete();
    b_pm = 0; b_pend = 0; b_vecnext = 0; b_vechave = 0; b_seendm = 0;
    b_open = 0; b_shift = 0; b_err = 0; b_cur = 0; b_vec = '0;
  endtask

  // monitor + target acknowledge model, every clock
  bit prev_wr_n = 1'b1;
  int ack_cnt = 0;
  int acc_num = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      check(tgt_map_sel === 1'b0 && tgt_boot_sel === 1'b1, "R1 straps",
            {tgt_map_sel, tgt_boot_sel}, 2'b01);
      check(io_sel_n === io_wr_n, "R7 select with write", io_sel_n, io_wr_n);
      check(tgt_latch === io_a0 && tgt_wr_n === (io_a0 | io_wr_n),
            "R8 strobe mapping", {tgt_latch, tgt_wr_n}, {io_a0, io_a0 | io_wr_n});
      if (in_ready && !io_wr_n) check(0, "R2 ready during access", 1, 0);
      if (done && exp_q.size() != 0) check(0, "R6 done early", exp_q.size(), 0);
      if (!io_wr_n && prev_wr_n) begin
        if (exp_q.size() == 0) check(0, "R9 unexpected access", {io_a0, io_data}, 0);
        else begin
          logic [18:0] e;
          string tg;
          e = exp_q.pop_front();
          case (e[18:17])
            2'd0: tg = "R3 access";
            2'd1: tg = "R4 access";
            2'd2: tg = "R5 access";
            default: tg = "R6 access";
          endcase
          check({io_a0, io_data} === e[16:0], tg, {io_a0, io_data}, e[16:0]);
        end
        acc_num++;
      end
      prev_wr_n = io_wr_n;
      if (!io_wr_n) begin
        ack_n = (ack_cnt >= (acc_num % 3)) ? 1'b0 : 1'b1;
        ack_cnt++;
      end else begin
        ack_n = 1'b1;
        ack_cnt = 0;
      end
    end else begin
      prev_wr_n = 1'b1;
      ack_n = 1'b1;
      ack_cnt = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic send(input logic [1:0] k, input logic [23:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_data = d;
    forever begin
      if (in_ready) begin @(posedge clk); break; end
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic m_hdr(input logic [1:0] t, input int a);
    if ((t != 2'b01 && t != 2'b10) || a > 16'h3FFF || (t == 2'b01 && b_seendm))
      b_err = 1;
    else begin
      b_pm = (t == 2'b01); b_cur = a; b_pend = 1; b_open = 1; b_shift = 0;
      b_vecnext = (t == 2'b01) && (a == 0);
      if (t == 2'b10) b_seendm = 1;
    end
    send(2'b01, {t, 22'(a)});
  endtask

  task automatic m_word(input logic [23:0] w);
    if (!b_open) b_err = 1;
    else if (b_vecnext) begin
      b_vec = w; b_vechave = 1; b_vecnext = 0; b_cur = 1; b_shift = 1;
    end else if (b_cur > 16'h3FFF) b_err = 1;
    else begin
      if (b_pend) exp_q.push_back({b_shift ? 2'd2 : 2'd0, 1'b1,
                                    1'b0, b_pm, b_cur[13:0]});
      b_pend = 0;
      if (b_pm) begin
        exp_q.push_back({2'd1, 1'b0, w[23:8]});
        exp_q.push_back({2'd1, 1'b0, 8'h00, w[7:0]});
      end else exp_q.push_back({2'd1, 1'b0, w[15:0]});
      b_cur++;
    end
    send(2'b10, w);
  endtask

  task automatic m_end();
    if (b_vechave) begin
      exp_q.push_back({2'd3, 1'b1, 16'h4000});
      exp_q.push_back({2'd3, 1'b0, b_vec[23:8]});
      exp_q.push_back({2'd3, 1'b0, 8'h00, b_vec[7:0]});
    end else b_err = 1;
    send(2'b11, 24'h0);
  endtask

  task automatic do_reset();
    model_clear();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(tgt_rst_n === 1'b0 && done === 1'b0 && err === 1'b0 && io_wr_n === 1'b1
          && in_ready === 1'b0, "R1 reset state",
          {tgt_rst_n, done, err, io_wr_n, in_ready}, 5'b00010);
    rst_n = 1'b1;
    for (int k = 1; k <= RST_CYC; k++) begin
      @(negedge clk);
      if (k == RST_CYC - 1) check(tgt_rst_n === 1'b0, "R1 reset still held", tgt_rst_n, 0);
      if (k == RST_CYC) check(tgt_rst_n === 1'b1, "R1 reset released", tgt_rst_n, 1);
    end
  endtask

  task automatic finish_scn(input bit want_err, input string req);
    int n = 0;
    while (!(done || err) && n < 2000) begin @(negedge clk); n++; end
    repeat (6) @(negedge clk);
    check(err === want_err && done === !want_err, req, {done, err}, {!want_err, want_err});
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    check(in_ready === 1'b0, want_err ? "R9 ready stays low" : "R6 ready after done",
          in_ready, 0);
  endtask

  initial begin
    model_clear();
    repeat (2) @(negedge clk);
    // normal image: vector record, second program record, data record
    do_reset();
    m_hdr(2'b01, 0);
    m_word(24'hA1B2C3); m_word(24'h123456); m_word(24'h789ABC);
    m_hdr(2'b01, 16'h0010);
    m_word(24'hDEF012); m_word(24'h0000FF);
    m_hdr(2'b10, 16'h0020);
    m_word(24'h00BEEF); m_word(24'hFF1234);
    m_end();
    finish_scn(0, "R6 normal image");

    // empty headers, vector-only record, data only
    do_reset();
    m_hdr(2'b01, 5);
    m_hdr(2'b01, 0); m_word(24'h5A5A5A);
    m_hdr(2'b10, 16'h0100);
    m_hdr(2'b10, 16'h3FFE);
    m_word(24'h001111); m_word(24'h002222);
    m_end();
    finish_scn(0, "R3 empty records");

    // R9 invalid kind
    do_reset();
    m_hdr(2'b01, 0); m_word(24'h111111);
    send(2'b00, 24'h0);
    finish_scn(1, "R9 invalid kind");

    // R9 address too large
    do_reset();
    m_hdr(2'b01, 0); m_word(24'h222222);
    m_hdr(2'b01, 16'h4000);
    finish_scn(1, "R9 address limit");

    // R9 program after data
    do_reset();
    m_hdr(2'b01, 0); m_word(24'h333333);
    m_hdr(2'b10, 3); m_word(24'h00AAAA);
    m_hdr(2'b01, 8);
    finish_scn(1, "R9 program after data");

    // R9 end without vector
    do_reset();
    m_hdr(2'b01, 1); m_word(24'h444444);
    m_end();
    finish_scn(1, "R9 no vector");

    // R9 word past top of memory
    do_reset();
    m_hdr(2'b01, 0); m_word(24'h555555);
    m_hdr(2'b01, 16'h3FFF); m_word(24'h666666); m_word(24'h777777);
    finish_scn(1, "R9 word overflow");

    // R9 unknown type, word before header
    do_reset();
    m_hdr(2'b11, 2);
    finish_scn(1, "R9 unknown type");
    do_reset();
    m_word(24'h888888);
    finish_scn(1, "R9 word before header");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule